// File: doc/BRIEF.md
# Branch Outcome History Recorder

This block keeps a compact running record of conditional outcomes for a trace unit that works in history mode. Each direct branch or predicated instruction reported to it adds one bit (1 for taken, 0 for not taken) to a history word. A single marker bit, the stop bit, sits just above the oldest recorded outcome so that a decoder can tell where the valid history starts. When the trace unit sends an indirect-branch message, the accumulated word and its length are handed to the message packer, and the record starts over.

If the word fills before an indirect message drains it, the block issues an overflow message by itself. That message carries a fixed resource code and the whole word, stop bit included, so no outcome is lost. A synchronization request is never attached to an overflow message. It is kept pending and delivered with the next indirect-message handoff. While history mode is off, the record stays empty and outcome events are dropped.

Top module: `brhist_tracker`

## Requirements
- R1: After reset both message valids are low and the record holds only the stop bit. A handoff requested before any outcome reports length 0 and a word of value 1.
- R2: With history mode on, each outcome event shifts its taken bit into bit 0 of the word, moving earlier bits and the stop bit up by one. The reported length equals the number of recorded outcomes.
- R3: When an outcome would put the stop bit into the top bit (HIST_W-1 outcomes recorded) and no handoff is requested, an overflow message appears on the next cycle with that full word. The record then restarts from the stop bit alone.
- R4: Every overflow message carries resource code 4'b0001 on rf_code.
- R5: A handoff request produces, one cycle later, ind_valid with the word and the length of the history recorded up to and including that cycle. The record then restarts from the stop bit alone.
- R6: An outcome event in the same cycle as a handoff request is part of the handed-off history.
- R7: If a handoff request and a filling outcome arrive together, only the handoff message is produced, and it carries the full word.
- R8: While hist_en is low, outcome events are ignored and the record is held at the stop bit alone, so a later handoff reports only outcomes recorded after re-enabling.
- R9: A synchronization request sets ind_sync on the next handoff message, including one requested in the same cycle. The request is held across any overflow messages in between and is cleared once delivered.
- R10: At most one of ind_valid and rf_valid is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hist_en | input | 1 | History mode enable |
| evt_valid | input | 1 | Outcome event strobe |
| evt_taken | input | 1 | Outcome of the event (1 = taken) |
| ind_req | input | 1 | Indirect-message handoff request |
| sync_req | input | 1 | Synchronization request |
| ind_valid | output | 1 | Handoff message valid |
| ind_hist | output | HIST_W (32) | Handed-off history word with stop bit |
| ind_len | output | LEN_W (5) | Number of outcomes in ind_hist |
| ind_sync | output | 1 | Synchronization attached to the handoff |
| rf_valid | output | 1 | Overflow message valid |
| rf_code | output | 4 | Resource code of the overflow message |
| rf_data | output | HIST_W (32) | Full history word with stop bit |

## Verification
Every result of this block is due exactly one cycle after the inputs that cause it. A handoff request, an outcome that fills the word, and a pending sync all show up on the message outputs after the next rising edge. The reference model in the bench updates on that same rising edge from the inputs it saw. Outputs and expectations are then compared on the following falling edge, while new inputs are applied at that falling edge, so no comparison straddles an edge. Overflow timing is checked against the model's own count of recorded outcomes rather than against any register in the design.

// File: rtl/bhb_pkg.sv
package bhb_pkg;
   localparam int RCODE_W = 4;

   typedef enum logic [1:0] {
      ACT_KEEP     = 2'd0,
      ACT_HANDOFF  = 2'd1,
      ACT_OVERFLOW = 2'd2
   } bhb_act_e;
endpackage

// File: rtl/bhb_shift.sv
// History word with stop-bit framing and its length
module bhb_shift #(
   parameter int HIST_W   = 32,
   parameter int LEN_W    = 5,
   parameter bit LEN_SCAN = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              evt_valid,
   input  logic              evt_taken,
   input  logic              clear,
   output logic [HIST_W-1:0] word_c,
   output logic [LEN_W-1:0]  len_c,
   output logic              full_c
);
   localparam logic [HIST_W-1:0] STOP = HIST_W'(1);

   logic [HIST_W-1:0] hist_q;
   logic              accept;

   assign accept = en && evt_valid;

   always_comb begin
      if (!en)
         word_c = STOP;
      else if (accept)
         word_c = {hist_q[HIST_W-2:0], evt_taken};
      else
         word_c = hist_q;
   end

   assign full_c = word_c[HIST_W-1];

   always_ff @(posedge clk) begin
      if (!rst_n)
         hist_q <= STOP;
      else
         hist_q <= clear ? STOP : word_c;
   end

   generate
      if (LEN_SCAN) begin : g_len_scan
         always_comb begin
            len_c = '0;
            for (int i = 0; i < HIST_W; i++)
               if (word_c[i]) len_c = LEN_W'(i);
         end
      end else begin : g_len_cnt
         logic [LEN_W-1:0] cnt_q;
         always_comb begin
            if (!en)
               len_c = '0;
            else if (accept)
               len_c = cnt_q + LEN_W'(1);
            else
               len_c = cnt_q;
         end
         always_ff @(posedge clk) begin
            if (!rst_n)
               cnt_q <= '0;
            else
               cnt_q <= clear ? '0 : len_c;
         end
      end
   endgenerate
endmodule

// File: rtl/bhb_sync_hold.sv
// Holds a sync request until the next handoff message
module bhb_sync_hold (
   input  logic clk,
   input  logic rst_n,
   input  logic sync_req,
   input  logic handoff,
   output logic sync_out
);
   logic pend_q;

   assign sync_out = pend_q || sync_req;

   always_ff @(posedge clk) begin
      if (!rst_n)
         pend_q <= 1'b0;
      else if (handoff)
         pend_q <= 1'b0;
      else
         pend_q <= sync_out;
   end
endmodule

// File: rtl/bhb_msg_out.sv
// Registered message fields
module bhb_msg_out
   import bhb_pkg::*;
#(
   parameter int HIST_W = 32,
   parameter int LEN_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  bhb_act_e          act,
   input  logic [HIST_W-1:0] word,
   input  logic [LEN_W-1:0]  len,
   input  logic              sync,
   output logic              ind_valid,
   output logic [HIST_W-1:0] ind_hist,
   output logic [LEN_W-1:0]  ind_len,
   output logic              ind_sync,
   output logic              rf_valid,
   output logic [HIST_W-1:0] rf_data
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ind_valid <= 1'b0;
         ind_hist  <= HIST_W'(1);
         ind_len   <= '0;
         ind_sync  <= 1'b0;
         rf_valid  <= 1'b0;
         rf_data   <= HIST_W'(1);
      end else begin
         ind_valid <= (act == ACT_HANDOFF);
         rf_valid  <= (act == ACT_OVERFLOW);
         if (act == ACT_HANDOFF) begin
            ind_hist <= word;
            ind_len  <= len;
            ind_sync <= sync;
         end
         if (act == ACT_OVERFLOW)
            rf_data <= word;
      end
   end
endmodule

// File: rtl/brhist_tracker.sv
module brhist_tracker
   import bhb_pkg::*;
#(
   parameter int                   HIST_W   = 32,
   parameter logic [RCODE_W-1:0]   RF_CODE  = 4'b0001,
   parameter bit                   LEN_SCAN = 1'b0,
   localparam int                  LEN_W    = $clog2(HIST_W)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               hist_en,
   input  logic               evt_valid,
   input  logic               evt_taken,
   input  logic               ind_req,
   input  logic               sync_req,
   output logic               ind_valid,
   output logic [HIST_W-1:0]  ind_hist,
   output logic [LEN_W-1:0]   ind_len,
   output logic               ind_sync,
   output logic               rf_valid,
   output logic [RCODE_W-1:0] rf_code,
   output logic [HIST_W-1:0]  rf_data
);
   initial begin
      if (HIST_W < 4 || HIST_W > 64)
         $error("HIST_W must be in 4..64");
      if ((1 << LEN_W) != HIST_W)
         $error("HIST_W must be a power of two");
   end

   logic [HIST_W-1:0] word_c;
   logic [LEN_W-1:0]  len_c;
   logic              full_c;
   logic              sync_c;
   bhb_act_e          act;

   always_comb begin
      if (ind_req)
         act = ACT_HANDOFF;
      else if (full_c)
         act = ACT_OVERFLOW;
      else
         act = ACT_KEEP;
   end

   bhb_shift #(.HIST_W(HIST_W), .LEN_W(LEN_W), .LEN_SCAN(LEN_SCAN)) u_shift (
      .clk(clk), .rst_n(rst_n), .en(hist_en), .evt_valid(evt_valid),
      .evt_taken(evt_taken), .clear(act != ACT_KEEP),
      .word_c(word_c), .len_c(len_c), .full_c(full_c)
   );

   bhb_sync_hold u_sync (
      .clk(clk), .rst_n(rst_n), .sync_req(sync_req),
      .handoff(act == ACT_HANDOFF), .sync_out(sync_c)
   );

   bhb_msg_out #(.HIST_W(HIST_W), .LEN_W(LEN_W)) u_out (
      .clk(clk), .rst_n(rst_n), .act(act), .word(word_c), .len(len_c),
      .sync(sync_c), .ind_valid(ind_valid), .ind_hist(ind_hist),
      .ind_len(ind_len), .ind_sync(ind_sync), .rf_valid(rf_valid),
      .rf_data(rf_data)
   );

   assign rf_code = RF_CODE;
endmodule

// File: rtl/brhist_tracker_chk.sv
module brhist_tracker_chk #(
   parameter int HIST_W = 32,
   localparam int LEN_W = $clog2(HIST_W)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              hist_en,
   input logic              ind_valid,
   input logic [HIST_W-1:0] ind_hist,
   input logic [LEN_W-1:0]  ind_len,
   input logic              rf_valid,
   input logic [HIST_W-1:0] rf_data
);
   assert_one_msg_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ind_valid, rf_valid}));

   assert_rf_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rf_valid |-> rf_data[HIST_W-1]);

   assert_rf_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rf_valid |=> !rf_valid);

   assert_stop_mark_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ind_valid |-> ((ind_hist >> ind_len) == HIST_W'(1)));

   assert_disabled_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ind_valid && !$past(hist_en)) |-> (ind_len == '0));
endmodule

bind brhist_tracker brhist_tracker_chk #(.HIST_W(HIST_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .hist_en(hist_en), .ind_valid(ind_valid),
   .ind_hist(ind_hist), .ind_len(ind_len), .rf_valid(rf_valid),
   .rf_data(rf_data)
);

// File: tb/brhist_tracker_tb.sv
module brhist_tracker_tb;
   localparam int W = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic hist_en = 1'b0, evt_valid = 1'b0, evt_taken = 1'b0;
   logic ind_req = 1'b0, sync_req = 1'b0;
   logic ind_valid, ind_sync, rf_valid;
   logic [W-1:0] ind_hist, rf_data;
   logic [4:0] ind_len;
   logic [3:0] rf_code;

   brhist_tracker u_dut (
      .clk(clk), .rst_n(rst_n), .hist_en(hist_en), .evt_valid(evt_valid),
      .evt_taken(evt_taken), .ind_req(ind_req), .sync_req(sync_req),
      .ind_valid(ind_valid), .ind_hist(ind_hist), .ind_len(ind_len),
      .ind_sync(ind_sync), .rf_valid(rf_valid), .rf_code(rf_code),
      .rf_data(rf_data)
   );

   always #5 clk = ~clk;

   int total = 0, bad = 0, cycles = 0;
   bit done = 0;
   string cur_req = "R1";

   // behavioural reference model
   bit q[$];
   bit pend = 0;
   bit e_ind = 0, e_rf = 0, e_sync = 0;
   int e_len = 0;
   logic [W-1:0] e_hist = 1, e_rfdata = 1;

   function automatic logic [W-1:0] pack_q();
      logic [W-1:0] w = 1;
      foreach (q[i]) w = (w << 1) | W'(q[i]);
      return w;
   endfunction

   always @(posedge clk) begin
      cycles++;
      if (!rst_n) begin
         q.delete(); pend = 0; e_ind = 0; e_rf = 0;
      end else begin
         e_ind = 0; e_rf = 0;
         if (!hist_en) q.delete();
         else if (evt_valid) q.push_back(evt_taken);
         if (ind_req) begin
            e_ind = 1; e_len = q.size(); e_hist = pack_q();
            e_sync = pend | sync_req; pend = 0; q.delete();
         end else begin
            pend = pend | sync_req;
            if (q.size() == W - 1) begin
               e_rf = 1; e_rfdata = pack_q(); q.delete();
            end
         end
      end
   end

   task automatic chk(bit ok, string req, string what, longint act, longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(ind_valid == e_ind, cur_req, "ind_valid", ind_valid, e_ind);
         chk(rf_valid == e_rf, "R3", "rf_valid", rf_valid, e_rf);
         chk(!(ind_valid && rf_valid), "R10", "both valid", 1, 0);
         if (e_ind && ind_valid) begin
            chk(ind_hist == e_hist, cur_req, "ind_hist", ind_hist, e_hist);
            chk(ind_len == e_len, cur_req, "ind_len", ind_len, e_len);
            chk(ind_sync == e_sync, "R9", "ind_sync", ind_sync, e_sync);
         end
         if (e_rf && rf_valid) begin
            chk(rf_data == e_rfdata, "R3", "rf_data", rf_data, e_rfdata);
            chk(rf_code == 4'b0001, "R4", "rf_code", rf_code, 1);
         end
      end
   end

   task automatic step(bit en, bit ev, bit tk, bit ind, bit sy);
      @(negedge clk);
      hist_en = en; evt_valid = ev; evt_taken = tk; ind_req = ind; sync_req = sy;
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) step(1, 0, 0, 0, 0);
   endtask

   task automatic summary();
      if (!done) begin
         done = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!ind_valid && !rf_valid, "R1", "valids after reset", {ind_valid, rf_valid}, 0);
      // R1: empty handoff
      cur_req = "R1";
      step(1, 0, 0, 1, 0); idle(2);
      // R2: shifting pattern with gaps
      cur_req = "R2";
      step(1, 1, 1, 0, 0); step(1, 0, 0, 0, 0); step(1, 1, 0, 0, 0);
      step(1, 1, 1, 0, 0); step(1, 1, 1, 0, 0); step(1, 1, 0, 0, 0);
      step(1, 0, 0, 1, 0); idle(2);
      // R6: event with handoff in the same cycle
      cur_req = "R6";
      step(1, 1, 0, 0, 0); step(1, 1, 1, 1, 0); idle(2);
      // R3 R4: fill twice
      cur_req = "R3";
      for (int i = 0; i < 70; i++) step(1, 1, i % 3 == 0, 0, 0);
      step(1, 0, 0, 1, 0); idle(2);
      // R7: filling outcome with handoff
      cur_req = "R7";
      for (int i = 0; i < 30; i++) step(1, 1, i[0], 0, 0);
      step(1, 1, 1, 1, 0); idle(2);
      // R8: disabled mode ignores events and empties record
      cur_req = "R8";
      for (int i = 0; i < 5; i++) step(1, 1, 1, 0, 0);
      for (int i = 0; i < 5; i++) step(0, 1, 1, 0, 0);
      step(0, 1, 1, 1, 0); idle(1);
      step(1, 1, 0, 0, 0); step(0, 1, 1, 0, 0); step(1, 1, 1, 0, 0);
      step(1, 0, 0, 1, 0); idle(2);
      // R9: sync held across overflow, then same-cycle sync
      cur_req = "R9";
      step(1, 0, 0, 0, 1);
      for (int i = 0; i < 35; i++) step(1, 1, 1, 0, 0);
      step(1, 0, 0, 1, 0); idle(1);
      step(1, 0, 0, 1, 0); idle(1);
      step(1, 1, 0, 1, 1); idle(2);
      // random mix
      cur_req = "R5";
      for (int i = 0; i < 3000; i++)
         step(($urandom % 16) != 0, ($urandom % 4) != 0, $urandom % 2,
              ($urandom % 40) == 0, ($urandom % 50) == 0);
      idle(3);
      summary();
   end

   always @(posedge clk) begin
      if (cycles > 100000 && !done) begin
         total++; bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
         summary();
      end
   end
endmodule